// File: doc/BRIEF.md
# Passive Serial Configuration Loader

This block is the master side of a serial configuration link for an SRAM-based programmable logic device. When the host pulses `start`, the loader pulls the device's active-low configuration request low for a fixed number of cycles and then releases it. It waits for the device's active-low status line to return high. It then reads the configuration image byte by byte from a synchronous external memory port. Each byte is streamed out on a single data line, least-significant bit first, with one pulse of a dedicated shift clock per bit.

Once the whole image has been sent, the loader keeps issuing bare shift clocks until the device raises its done line. If done does not appear within a bounded number of clocks, the load fails. After done is seen, a fixed number of further clocks lets the device finish its internal initialization, and the host then sees `done`. If the status line drops during the load, or done never arrives, the loader stops the clock and raises `error` instead. Because the serial link has no minimum clock rate, the shift clock simply pauses while the next byte is fetched.

Top module: `ps_cfg_loader`

## Requirements
- R1: While reset is asserted and directly after it, `busy`, `done`, `error`, `memRdEn` and `cfgClk` are 0 and `cfgReqN` is 1.
- R2: A `start` seen while idle clears `done` and `error`, raises `busy` on the next cycle, and holds `cfgReqN` low for exactly REQ_CYCLES cycles. A `start` seen while `busy` is high has no effect.
- R3: `cfgClk` stays low while `cfgReqN` is low, and also after the request is released until `devStatusN` has been seen high.
- R4: The image is read at addresses 0, 1, …, IMAGE_BYTES-1 in ascending order, one read per `memRdEn` pulse. `memData` is taken in the cycle after the pulse.
- R5: Each byte is sent bit 0 first and bit 7 last. Each bit is sampled on a rising edge of `cfgClk`. `cfgData` changes only while `cfgClk` is low, and `cfgClk` is high for exactly one cycle per pulse.
- R6: After the last data bit, the loader issues bare `cfgClk` pulses until `devDone` is seen high, issuing at most DONE_WAIT_CLKS of them. Done seen after exactly DONE_WAIT_CLKS pulses still succeeds.
- R7: If `devDone` is still low after DONE_WAIT_CLKS bare pulses, the loader issues no further pulses, sets `error` and drops `busy`.
- R8: If `devStatusN` goes low between the start of the first fetch and the detection of done, the load aborts. No further `cfgClk` rising edge follows, `error` is set and `busy` drops. While `busy` is low, `cfgClk` is low.
- R9: After `devDone` is seen, exactly INIT_CLKS further `cfgClk` pulses are issued. Then `done` rises and `busy` falls in the same cycle.
- R10: `done` and `error` are never high together, and each holds its value until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Host request to begin a load (one-cycle pulse) |
| busy | output | 1 | A load is in progress |
| done | output | 1 | Last load completed successfully (held) |
| error | output | 1 | Last load failed (held) |
| memRdEn | output | 1 | Read strobe to the image memory |
| memAddr | output | AW (15 by default) | Byte address of the image memory |
| memData | input | 8 | Image byte, valid the cycle after `memRdEn` |
| cfgReqN | output | 1 | Active-low configuration request to the device |
| devStatusN | input | 1 | Active-low device status (high = ready / no fault) |
| cfgClk | output | 1 | Serial shift clock; device samples on its rising edge |
| cfgData | output | 1 | Serial configuration data |
| devDone | input | 1 | Device reports configuration complete |

## Verification
The bench builds the loader with a 16-byte image, a 4-cycle request, a 10-clock done window and 5 initialization clocks. At these sizes every address, every bit of every byte and both ends of the done window fall within a few hundred cycles. This brings into reach a done that arrives on the very last allowed clock, a done that arrives together with the last data bit, a done that never comes, and a status fault in the middle of the fifth byte. A behavioural device model answers the request and counts every shift-clock edge. This lets the bench check the exact pulse counts around done against the parameters.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;

  // Strobes from the control FSM to the datapath, one cycle each.
  typedef struct packed {
    logic addrClr;   // rewind image address
    logic addrInc;   // advance image address
    logic loadByte;  // write memData into the shift engine (8 bits)
    logic loadTick;  // start one bare clock pulse (data held)
    logic abort;     // stop the shift engine, clock forced low
    logic cntClr;    // clear general-purpose counter
    logic cntInc;    // advance general-purpose counter
  } dpCmd_t;

endpackage

// File: rtl/ps_cfg_datapath.sv
module ps_cfg_datapath
  import ps_cfg_pkg::*;
#(
  parameter int IMAGE_BYTES = 29696,
  parameter int AW = 15,
  parameter int CW = 13
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCmd_t        cmd,
  input  logic [7:0]    memData,
  output logic [AW-1:0] memAddr,
  output logic          cfgClk,
  output logic          cfgData,
  output logic          byteDone,
  output logic          addrLast,
  output logic [CW-1:0] cnt
);

  localparam logic [AW-1:0] ADDR_END = AW'(IMAGE_BYTES);

  logic [AW-1:0] addrQ;
  logic [CW-1:0] cntQ;
  logic [7:0]    shiftQ;
  logic [3:0]    bitsLeft;
  logic          clkQ;
  logic          dataQ;
  logic          doneQ;

  // Address and general counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      cntQ  <= '0;
    end else begin
      if (cmd.addrClr)      addrQ <= '0;
      else if (cmd.addrInc) addrQ <= addrQ + 1'b1;
      if (cmd.cntClr)       cntQ  <= '0;
      else if (cmd.cntInc)  cntQ  <= cntQ + 1'b1;
    end
  end

  // Write-triggered shift engine: low phase presents data, high phase lets the device sample.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ   <= '0;
      bitsLeft <= '0;
      clkQ     <= 1'b0;
      dataQ    <= 1'b0;
      doneQ    <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (cmd.abort) begin
        bitsLeft <= '0;
        clkQ     <= 1'b0;
      end else if (cmd.loadByte) begin
        dataQ    <= memData[0];
        shiftQ   <= {1'b0, memData[7:1]};
        bitsLeft <= 4'd8;
        clkQ     <= 1'b0;
      end else if (cmd.loadTick) begin
        bitsLeft <= 4'd1;
        clkQ     <= 1'b0;
      end else if (bitsLeft != 4'd0) begin
        if (!clkQ) begin
          clkQ <= 1'b1;
        end else begin
          clkQ     <= 1'b0;
          bitsLeft <= bitsLeft - 4'd1;
          if (bitsLeft == 4'd1) begin
            doneQ <= 1'b1;
          end else begin
            dataQ  <= shiftQ[0];
            shiftQ <= {1'b0, shiftQ[7:1]};
          end
        end
      end
    end
  end

  assign memAddr  = addrQ;
  assign cnt      = cntQ;
  assign cfgClk   = clkQ;
  assign cfgData  = dataQ;
  assign byteDone = doneQ;
  assign addrLast = (addrQ == ADDR_END);

endmodule

// File: rtl/ps_cfg_ctrl.sv
module ps_cfg_ctrl
  import ps_cfg_pkg::*;
#(
  parameter int CW = 13,
  parameter int REQ_CYCLES = 50,
  parameter int DONE_WAIT_CLKS = 4096,
  parameter int INIT_CLKS = 40
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          devStatusN,
  input  logic          devDone,
  input  logic          byteDone,
  input  logic          addrLast,
  input  logic [CW-1:0] cnt,
  output dpCmd_t        cmd,
  output logic          busy,
  output logic          done,
  output logic          error,
  output logic          cfgReqN,
  output logic          memRdEn
);

  localparam logic [CW-1:0] REQ_LAST  = CW'(REQ_CYCLES - 1);
  localparam logic [CW-1:0] WAIT_LAST = CW'(DONE_WAIT_CLKS);
  localparam logic [CW-1:0] INIT_LAST = CW'(INIT_CLKS);

  typedef enum logic [3:0] {
    S_IDLE, S_REQ, S_WSTAT, S_FETCH, S_LOAD, S_SHIFT,
    S_WDCHK, S_WDWAIT, S_INCHK, S_INWAIT
  } state_t;

  state_t st, nxt;
  logic   setDone, setErr, clrFlags;
  logic   doneQ, errQ;
  logic   inStream;

  assign inStream = (st == S_FETCH) || (st == S_LOAD) || (st == S_SHIFT) ||
                    (st == S_WDCHK) || (st == S_WDWAIT);

  always_comb begin
    nxt      = st;
    cmd      = '0;
    setDone  = 1'b0;
    setErr   = 1'b0;
    clrFlags = 1'b0;
    unique case (st)
      S_IDLE: if (start) begin
        clrFlags    = 1'b1;
        cmd.cntClr  = 1'b1;
        cmd.addrClr = 1'b1;
        nxt         = S_REQ;
      end
      S_REQ: begin
        if (cnt == REQ_LAST) nxt = S_WSTAT;
        else                 cmd.cntInc = 1'b1;
      end
      S_WSTAT: if (devStatusN) nxt = S_FETCH;
      S_FETCH: nxt = S_LOAD;
      S_LOAD: begin
        cmd.loadByte = 1'b1;
        cmd.addrInc  = 1'b1;
        nxt          = S_SHIFT;
      end
      S_SHIFT: if (byteDone) begin
        if (addrLast) begin
          cmd.cntClr = 1'b1;
          nxt        = S_WDCHK;
        end else begin
          nxt = S_FETCH;
        end
      end
      S_WDCHK: begin
        if (devDone) begin
          cmd.cntClr = 1'b1;
          nxt        = S_INCHK;
        end else if (cnt == WAIT_LAST) begin
          cmd.abort = 1'b1;
          setErr    = 1'b1;
          nxt       = S_IDLE;
        end else begin
          cmd.loadTick = 1'b1;
          cmd.cntInc   = 1'b1;
          nxt          = S_WDWAIT;
        end
      end
      S_WDWAIT: if (byteDone) nxt = S_WDCHK;
      S_INCHK: begin
        if (cnt == INIT_LAST) begin
          setDone = 1'b1;
          nxt     = S_IDLE;
        end else begin
          cmd.loadTick = 1'b1;
          cmd.cntInc   = 1'b1;
          nxt          = S_INWAIT;
        end
      end
      S_INWAIT: if (byteDone) nxt = S_INCHK;
      default: nxt = S_IDLE;
    endcase
    // A status fault overrides whatever the streaming states wanted to do.
    if (inStream && !devStatusN) begin
      cmd       = '0;
      cmd.abort = 1'b1;
      setErr    = 1'b1;
      setDone   = 1'b0;
      nxt       = S_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st    <= S_IDLE;
      doneQ <= 1'b0;
      errQ  <= 1'b0;
    end else begin
      st <= nxt;
      if (clrFlags) begin
        doneQ <= 1'b0;
        errQ  <= 1'b0;
      end else begin
        if (setDone) doneQ <= 1'b1;
        if (setErr)  errQ  <= 1'b1;
      end
    end
  end

  assign busy    = (st != S_IDLE);
  assign done    = doneQ;
  assign error   = errQ;
  assign cfgReqN = (st != S_REQ);
  assign memRdEn = (st == S_FETCH) && devStatusN;

endmodule

// File: rtl/ps_cfg_loader.sv
module ps_cfg_loader
  import ps_cfg_pkg::*;
#(
  parameter int IMAGE_BYTES    = 29696,
  parameter int REQ_CYCLES     = 50,
  parameter int DONE_WAIT_CLKS = 4096,
  parameter int INIT_CLKS      = 40,
  localparam int AW_MIN = $clog2(IMAGE_BYTES + 1),
  localparam int AW     = (AW_MIN > 15) ? AW_MIN : 15
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          error,
  output logic          memRdEn,
  output logic [AW-1:0] memAddr,
  input  logic [7:0]    memData,
  output logic          cfgReqN,
  input  logic          devStatusN,
  output logic          cfgClk,
  output logic          cfgData,
  input  logic          devDone
);

  localparam int MAX_A = (REQ_CYCLES > DONE_WAIT_CLKS) ? REQ_CYCLES : DONE_WAIT_CLKS;
  localparam int MAX_C = (MAX_A > INIT_CLKS) ? MAX_A : INIT_CLKS;
  localparam int CW    = $clog2(MAX_C + 1);

  dpCmd_t        cmd;
  logic          byteDone;
  logic          addrLast;
  logic [CW-1:0] cnt;

  ps_cfg_ctrl #(
    .CW(CW), .REQ_CYCLES(REQ_CYCLES),
    .DONE_WAIT_CLKS(DONE_WAIT_CLKS), .INIT_CLKS(INIT_CLKS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .devStatusN(devStatusN),
    .devDone(devDone), .byteDone(byteDone), .addrLast(addrLast), .cnt(cnt),
    .cmd(cmd), .busy(busy), .done(done), .error(error),
    .cfgReqN(cfgReqN), .memRdEn(memRdEn)
  );

  ps_cfg_datapath #(
    .IMAGE_BYTES(IMAGE_BYTES), .AW(AW), .CW(CW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .memData(memData),
    .memAddr(memAddr), .cfgClk(cfgClk), .cfgData(cfgData),
    .byteDone(byteDone), .addrLast(addrLast), .cnt(cnt)
  );

endmodule

// File: rtl/ps_cfg_loader_chk.sv
module ps_cfg_loader_chk (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic busy,
  input logic done,
  input logic error,
  input logic memRdEn,
  input logic cfgReqN,
  input logic cfgClk,
  input logic cfgData
);

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (busy && !cfgReqN && !done && !error));

  // R3
  req_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgReqN |-> !cfgClk);

  // R4
  read_in_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> (busy && cfgReqN));

  // R5
  data_setup_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgClk) |-> $stable(cfgData));

  // R5
  clk_single_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgClk |=> !cfgClk);

  // R8
  idle_clk_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !cfgClk);

  // R10
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error));

endmodule

bind ps_cfg_loader ps_cfg_loader_chk u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .error(error), .memRdEn(memRdEn), .cfgReqN(cfgReqN),
  .cfgClk(cfgClk), .cfgData(cfgData)
);

// File: tb/ps_cfg_loader_bench.sv
module ps_cfg_loader_bench;

  localparam int IMG = 16;
  localparam int REQ = 4;
  localparam int DW  = 10;
  localparam int INI = 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        busy, done, error, memRdEn, cfgReqN, cfgClk, cfgData;
  logic [14:0] memAddr;
  logic [7:0]  memData = 8'h00;
  logic        devStatusN = 1'b1;
  logic        devDone = 1'b0;

  int checks = 0;
  int errors = 0;

  // Scenario controls and observed counts (behavioural device model)
  int statDelay, doneAfter, faultBit;
  int bitIdx, extraCnt, initCnt, reqLow, reqPulses, earlyClk, expAddr, statCnt;
  bit faulted, prevClk, prevReq, prevData;

  always #2 clk = ~clk;

  ps_cfg_loader #(
    .IMAGE_BYTES(IMG), .REQ_CYCLES(REQ), .DONE_WAIT_CLKS(DW), .INIT_CLKS(INI)
  ) u_ps_cfg_loader (
    .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
    .error(error), .memRdEn(memRdEn), .memAddr(memAddr), .memData(memData),
    .cfgReqN(cfgReqN), .devStatusN(devStatusN), .cfgClk(cfgClk),
    .cfgData(cfgData), .devDone(devDone)
  );

  function automatic logic [7:0] img(input int a);
    return 8'((a * 53 + 17) ^ (a >> 1));
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Synchronous image memory
  always @(posedge clk) if (memRdEn) memData <= img(int'(memAddr));

  // Monitor and device model, all at the falling edge
  always @(negedge clk) begin
    if (rstN) begin
      logic [7:0] b;
      if (!busy) chk(!cfgClk && cfgReqN, "R8", "idle clock/request", int'(cfgClk), 0);
      if (!cfgReqN) reqLow++;
      if (!cfgReqN && prevReq) reqPulses++;
      if (memRdEn) begin
        chk(int'(memAddr) == expAddr, "R4", "read address", int'(memAddr), expAddr);
        expAddr++;
      end
      if (cfgClk && !prevClk) begin
        if (!devStatusN) earlyClk++;
        if (bitIdx < IMG * 8) begin
          b = img(bitIdx / 8);
          chk(cfgData == b[bitIdx % 8], "R5", "serial bit", int'(cfgData), int'(b[bitIdx % 8]));
          chk(cfgData == prevData, "R5", "data setup before rise", int'(cfgData), int'(prevData));
          bitIdx++;
          if (bitIdx == IMG * 8 && doneAfter == 0) devDone = 1'b1;
          if (bitIdx == faultBit) begin
            faulted    = 1'b1;
            devStatusN = 1'b0;
          end
        end else if (devDone) begin
          initCnt++;
        end else begin
          extraCnt++;
          if (extraCnt == doneAfter) devDone = 1'b1;
        end
      end
      if (!cfgReqN) begin
        devStatusN = 1'b0;
        statCnt    = 0;
        devDone    = 1'b0;
      end else if (!faulted && !devStatusN) begin
        if (statCnt >= statDelay) devStatusN = 1'b1;
        else statCnt++;
      end
      prevClk  = cfgClk;
      prevReq  = cfgReqN;
      prevData = cfgData;
    end
  end

  task automatic runCfg(input int sd, input int da, input int fb, input bit midStart);
    statDelay = sd; doneAfter = da; faultBit = fb; faulted = 1'b0;
    bitIdx = 0; extraCnt = 0; initCnt = 0; reqLow = 0; reqPulses = 0;
    earlyClk = 0; expAddr = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (midStart) begin
      repeat (40) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
  endtask

  initial begin
    statDelay = 0; doneAfter = -1; faultBit = -1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !error, "R1", "flags in reset", int'(busy), 0);
    chk(cfgReqN && !cfgClk && !memRdEn, "R1", "device pins in reset", int'(cfgReqN), 1);
    rstN = 1'b1;
    prevReq = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !done && !error && cfgReqN, "R1", "idle after reset", int'(busy), 0);

    // Normal load, with a start during the load that must be ignored
    runCfg(3, 2, -1, 1'b1);
    chk(reqLow == REQ, "R2", "request low cycles", reqLow, REQ);
    chk(reqPulses == 1, "R2", "request pulses (start while busy)", reqPulses, 1);
    chk(earlyClk == 0, "R3", "clock edges before status ready", earlyClk, 0);
    chk(expAddr == IMG, "R4", "bytes read", expAddr, IMG);
    chk(bitIdx == IMG * 8, "R5", "bits streamed", bitIdx, IMG * 8);
    chk(extraCnt == 2, "R6", "clocks before done", extraCnt, 2);
    chk(initCnt == INI, "R9", "init clocks", initCnt, INI);
    chk(done && !error, "R9", "done flag", int'(done), 1);

    // Done together with last bit, slow status
    runCfg(20, 0, -1, 1'b0);
    chk(earlyClk == 0, "R3", "no clock during long status wait", earlyClk, 0);
    chk(extraCnt == 0, "R6", "no bare clocks needed", extraCnt, 0);
    chk(initCnt == INI, "R9", "init clocks (early done)", initCnt, INI);
    chk(done, "R6", "done with early device done", int'(done), 1);

    // Done on the last allowed clock
    runCfg(1, DW, -1, 1'b0);
    chk(extraCnt == DW, "R6", "clocks at window edge", extraCnt, DW);
    chk(done && !error, "R6", "success at window edge", int'(error), 0);

    // Done never arrives
    runCfg(1, -1, -1, 1'b0);
    chk(extraCnt == DW, "R7", "bare clocks before timeout", extraCnt, DW);
    chk(initCnt == 0, "R7", "no clocks after timeout", initCnt, 0);
    chk(error && !done, "R7", "error after timeout", int'(error), 1);
    repeat (10) @(negedge clk);
    chk(error && !done, "R10", "error held while idle", int'(error), 1);

    // Status fault in mid-stream
    runCfg(2, 3, 37, 1'b0);
    chk(bitIdx == 37, "R8", "bits before abort", bitIdx, 37);
    chk(error && !done, "R8", "error after status fault", int'(error), 1);

    // Fresh start clears the error
    runCfg(0, 1, -1, 1'b0);
    chk(!error && done, "R10", "start clears error", int'(error), 0);
    chk(bitIdx == IMG * 8, "R5", "bits streamed after recovery", bitIdx, IMG * 8);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule